// File: doc/BRIEF.md
# Single-wire chunk codec with parity

This block moves fixed-width chunks over one shared data line that is pulled high and only ever pulled low or driven by an output enable. The transmit half frames each chunk with a synchronisation pulse. The line is held low for one bit period and then raised for a single clock cycle. The data bits follow with the most significant bit first, and an even-parity bit comes after them. The transmitter then keeps the line driven low, so that the next chunk's pulse produces a fresh rising edge. The receive half watches the synchronised line for a low level followed by a rising edge. It samples each bit a fixed fraction into the bit and reports the byte together with a parity-error flag.

The chunk width and the bit period are parameters. The bit period is counted in clock cycles, so the supported line rates (bit times of 4 to 48 microseconds, with 6 as the usual choice) come from choosing it against the clock. Each side has a valid/ready handshake. Multi-chunk packets, line turnaround and transaction framing belong to the logic around this block.

Top module: `swire_chunk_codec`

## Requirements
- R1: When a chunk is accepted (tx_valid and tx_ready high at a clock edge), line_oe is 1 and line_out is 0 for exactly BIT_CYCLES cycles, starting with the cycle after that edge.
- R2: Directly after that low phase, line_out is 1 for exactly one cycle. This rising edge is the synchronisation mark.
- R3: The data bits follow the mark with the most significant bit first. Each bit is held for BIT_CYCLES cycles, and line_out equals the bit value.
- R4: After the last data bit, one more bit period carries the parity bit. The parity bit is the XOR of all data bits, so the data bits and the parity bit together hold an even number of ones.
- R5: After the parity bit, the line stays driven low (line_oe 1, line_out 0) until the next chunk is accepted. Once line_oe has risen it never falls again before reset.
- R6: tx_ready is 0 from the accepting edge until the parity bit ends. A tx_valid or tx_data change during that time has no effect on the line.
- R7: The receiver waits for a low level and then a rising edge on the line. Bit 0 begins one cycle after that edge. Each bit is sampled floor(BIT_CYCLES/2) cycles into the bit, with a further BIT_CYCLES - floor(BIT_CYCLES/2) cycles to the next bit. Bits are shifted in most significant first and presented on rx_data.
- R8: rx_parity_error is 1 exactly when the sampled parity bit differs from the XOR of the received data bits.
- R9: rx_valid, rx_data and rx_parity_error stay unchanged until rx_ready is high. While a result is waiting, the receiver does not look for a new chunk, and a chunk that passes in that time is not captured.
- R10: During and directly after reset, line_oe is 0, tx_ready is 1 and rx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | A chunk is offered for sending |
| tx_ready | output | 1 | The transmitter can accept a chunk |
| tx_data | input | CHUNK_BITS | Chunk to send |
| rx_valid | output | 1 | A received chunk is waiting |
| rx_ready | input | 1 | The consumer takes the waiting chunk |
| rx_data | output | CHUNK_BITS | Received chunk |
| rx_parity_error | output | 1 | Parity mismatch for the waiting chunk |
| line_oe | output | 1 | Drive enable for the shared line |
| line_out | output | 1 | Value driven while line_oe is 1 |
| line_in | input | 1 | Asynchronous level seen on the line |

## Verification
Every cycle, the assertions check the following: an accepted chunk starts with a driven low, the one-cycle mark follows a driven low, the drive stays low and enabled while the transmitter is idle, and a received result holds still until it is taken. They also check that a chunk is never completed while a previous result is still waiting. Three things depend on the bench's scenarios. These are the exact length of every phase on the line, the bit order and parity value for particular bytes, and the receiver's mid-bit sampling against a half-cycle-skewed peer. The same scenarios cover the injected parity faults, the chunk that is lost while a result is held, and the loop-back of the block's own chunks through its receiver.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_SYNC,
    TX_MARK,
    TX_DATA,
    TX_PAR,
    TX_TAIL
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_HUNT,
    RX_WAIT_HIGH,
    RX_BITS
  } rx_state_e;

  // Cycles from the start of a bit to its sampling point.
  function automatic int unsigned lead_half(input int unsigned period);
    return period / 2;
  endfunction

  // Cycles from the sampling point to the end of the bit.
  function automatic int unsigned trail_half(input int unsigned period);
    return period - (period / 2);
  endfunction

  // Even parity: one when the word holds an odd number of ones.
  function automatic logic even_parity(input logic [31:0] word);
    return ^word;
  endfunction

endpackage

// File: rtl/swc_line_sync.sv
module swc_line_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= IDLE_VAL;
    else        stage_q[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= IDLE_VAL;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/swc_tx.sv
module swc_tx
  import swc_pkg::*;
#(
  parameter int unsigned CHUNK_BITS = 8,
  parameter int unsigned BIT_CYCLES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [CHUNK_BITS-1:0] tx_data,
  output logic                  line_oe,
  output logic                  line_out
);

  localparam int unsigned CW = $clog2(BIT_CYCLES);
  localparam int unsigned IW = $clog2(CHUNK_BITS + 1);
  localparam logic [CW-1:0] LAST_CYC = CW'(BIT_CYCLES - 1);
  localparam logic [IW-1:0] LAST_BIT = IW'(CHUNK_BITS - 1);

  tx_state_e             state_q;
  logic [CW-1:0]         cyc_q;
  logic [IW-1:0]         bit_q;
  logic [CHUNK_BITS-1:0] shift_q;
  logic                  par_q;

  // Named events for the checks below.
  logic accept_evt;
  logic mark_evt;
  logic period_end;

  assign tx_ready   = (state_q == TX_IDLE) || (state_q == TX_TAIL);
  assign accept_evt = tx_valid && tx_ready;
  assign mark_evt   = (state_q == TX_MARK);
  assign period_end = (cyc_q == LAST_CYC);

  assign line_oe  = (state_q != TX_IDLE);
  assign line_out = mark_evt
                  || ((state_q == TX_DATA) && shift_q[CHUNK_BITS-1])
                  || ((state_q == TX_PAR) && par_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cyc_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
    end else begin
      case (state_q)
        TX_IDLE, TX_TAIL: begin
          if (accept_evt) begin
            state_q <= TX_SYNC;
            cyc_q   <= '0;
            shift_q <= tx_data;
            par_q   <= even_parity(32'(tx_data));
          end
        end
        TX_SYNC: begin
          if (period_end) begin
            state_q <= TX_MARK;
            cyc_q   <= '0;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        TX_MARK: begin
          state_q <= TX_DATA;
          cyc_q   <= '0;
          bit_q   <= '0;
        end
        TX_DATA: begin
          if (period_end) begin
            cyc_q   <= '0;
            shift_q <= {shift_q[CHUNK_BITS-2:0], 1'b0};
            if (bit_q == LAST_BIT) state_q <= TX_PAR;
            else                   bit_q   <= bit_q + 1'b1;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        TX_PAR: begin
          if (period_end) begin
            state_q <= TX_TAIL;
            cyc_q   <= '0;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  // R1: an accepted chunk begins with a driven low level.
  p_sync_starts_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (line_oe && !line_out));

  // R2: the mark lasts one cycle and follows a driven low.
  p_mark_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mark_evt |-> $past(line_oe && !line_out));
  p_mark_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mark_evt |=> !mark_evt);

  // R5: between chunks the line stays driven low, and the drive is never dropped.
  p_tail_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && tx_ready) |-> !line_out);
  p_drive_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |=> line_oe);

endmodule

// File: rtl/swc_rx.sv
module swc_rx
  import swc_pkg::*;
#(
  parameter int unsigned CHUNK_BITS = 8,
  parameter int unsigned BIT_CYCLES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_q,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [CHUNK_BITS-1:0] rx_data,
  output logic                  rx_parity_error
);

  localparam int unsigned CW = $clog2(BIT_CYCLES);
  localparam int unsigned IW = $clog2(CHUNK_BITS + 1);
  localparam int unsigned H1 = lead_half(BIT_CYCLES);
  localparam int unsigned H2 = trail_half(BIT_CYCLES);
  localparam logic [CW-1:0] SAMPLE_AT = CW'(H1);
  localparam logic [CW-1:0] WRAP_AT   = CW'(H1 + H2 - 1);
  localparam logic [IW-1:0] PAR_SLOT  = IW'(CHUNK_BITS);

  rx_state_e             state_q;
  logic [CW-1:0]         cyc_q;
  logic [IW-1:0]         bit_q;
  logic [CHUNK_BITS-1:0] shift_q;
  logic                  valid_q;
  logic [CHUNK_BITS-1:0] data_q;
  logic                  err_q;

  // Named events for the checks below.
  logic sample_evt;
  logic done_evt;
  logic take_evt;

  assign sample_evt = (state_q == RX_BITS) && (cyc_q == SAMPLE_AT);
  assign done_evt   = sample_evt && (bit_q == PAR_SLOT);
  assign take_evt   = valid_q && rx_ready;

  assign rx_valid        = valid_q;
  assign rx_data         = data_q;
  assign rx_parity_error = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      cyc_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (take_evt) valid_q <= 1'b0;
      case (state_q)
        RX_HUNT: begin
          if (!valid_q && !line_q) state_q <= RX_WAIT_HIGH;
        end
        RX_WAIT_HIGH: begin
          if (line_q) begin
            state_q <= RX_BITS;
            cyc_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
          end
        end
        RX_BITS: begin
          if (done_evt) begin
            data_q  <= shift_q;
            err_q   <= even_parity(32'(shift_q)) ^ line_q;
            valid_q <= 1'b1;
            state_q <= RX_HUNT;
          end else if (sample_evt) begin
            shift_q <= {shift_q[CHUNK_BITS-2:0], line_q};
          end
          if (cyc_q == WRAP_AT) begin
            cyc_q <= '0;
            bit_q <= bit_q + 1'b1;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  // R9: a waiting result holds still until it is taken.
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_parity_error)));

  // R9: a chunk completes only when no earlier result is waiting.
  p_done_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> !rx_valid);

endmodule

// File: rtl/swire_chunk_codec.sv
module swire_chunk_codec #(
  parameter int unsigned CHUNK_BITS = 8,
  parameter int unsigned BIT_CYCLES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [CHUNK_BITS-1:0] tx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [CHUNK_BITS-1:0] rx_data,
  output logic                  rx_parity_error,
  output logic                  line_oe,
  output logic                  line_out,
  input  logic                  line_in
);

  logic line_sync;

  swc_line_sync #(
    .STAGES  (2),
    .IDLE_VAL(1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(line_in),
    .sync_out(line_sync)
  );

  swc_tx #(
    .CHUNK_BITS(CHUNK_BITS),
    .BIT_CYCLES(BIT_CYCLES)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_data (tx_data),
    .line_oe (line_oe),
    .line_out(line_out)
  );

  swc_rx #(
    .CHUNK_BITS(CHUNK_BITS),
    .BIT_CYCLES(BIT_CYCLES)
  ) u_rx (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_q         (line_sync),
    .rx_valid       (rx_valid),
    .rx_ready       (rx_ready),
    .rx_data        (rx_data),
    .rx_parity_error(rx_parity_error)
  );

endmodule

// File: tb/swire_chunk_codec_tb.sv
module swire_chunk_codec_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int T = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic [N-1:0] tx_data = '0;
  logic tx_ready;
  logic rx_valid;
  logic [N-1:0] rx_data;
  logic rx_parity_error;
  logic line_oe, line_out;
  logic peer_low = 1'b0;
  logic hold_rx = 1'b0;
  logic rx_ready;
  logic line_in;

  int checks = 0;
  int fails = 0;
  logic [N:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_ready = !hold_rx;
  assign line_in  = (line_oe ? line_out : 1'b1) & ~peer_low;

  swire_chunk_codec #(.CHUNK_BITS(N), .BIT_CYCLES(T)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_parity_error(rx_parity_error),
    .line_oe(line_oe), .line_out(line_out), .line_in(line_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Scoreboard monitor: pops an expected {error, data} item for every handshake.
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected result", int'(rx_data), -1);
      end else begin
        logic [N:0] e;
        e = exp_q.pop_front();
        check(rx_data == e[N-1:0], "R7 rx_data", int'(rx_data), int'(e[N-1:0]));
        check(rx_parity_error == e[N], "R8 rx_parity_error", int'(rx_parity_error), int'(e[N]));
      end
    end
  end

  // Peer drives a framed chunk through its own pull-down; the line is left low afterwards.
  task automatic peer_chunk(input logic [N-1:0] d, input bit flip, input bit expect_it);
    logic p;
    p = (^d) ^ flip;
    if (expect_it) exp_q.push_back({flip, d});
    @(negedge clk);
    peer_low = 1'b1;
    repeat (T) @(negedge clk);
    peer_low = 1'b0;
    @(negedge clk);
    for (int b = N - 1; b >= 0; b--) begin
      peer_low = !d[b];
      repeat (T) @(negedge clk);
    end
    peer_low = !p;
    repeat (T) @(negedge clk);
    peer_low = 1'b1;
  endtask

  // Sends one chunk and compares every cycle of the line against the expected frame.
  task automatic tx_chunk(input logic [N-1:0] d, input bit poke);
    int total, e_sync, e_mark, e_data, e_par, e_tail, e_rdy;
    logic expv, lv;
    total = T + 1 + N * T + T + 1;
    e_sync = 0; e_mark = 0; e_data = 0; e_par = 0; e_tail = 0; e_rdy = 0;
    exp_q.push_back({1'b0, d});
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int i = 0; i < total; i++) begin
      lv = line_oe ? line_out : 1'b1;
      if (i < T) begin
        if (!(line_oe && lv == 1'b0)) e_sync++;
      end else if (i == T) begin
        if (!(line_oe && lv == 1'b1)) e_mark++;
      end else if (i < T + 1 + N * T) begin
        expv = d[N - 1 - (i - T - 1) / T];
        if (lv != expv) e_data++;
      end else if (i < T + 1 + N * T + T) begin
        if (lv != ^d) e_par++;
      end else begin
        if (!(line_oe && lv == 1'b0)) e_tail++;
      end
      if (i < total - 1) begin
        if (tx_ready) e_rdy++;
      end else begin
        if (!tx_ready) e_rdy++;
      end
      if (poke && i == T + 3) begin
        tx_valid = 1'b1;
        tx_data  = ~d;
      end
      if (poke && i == T + 8) tx_valid = 1'b0;
      if (i < total - 1) @(negedge clk);
    end
    check(e_sync == 0, "R1 sync low phase mismatches", e_sync, 0);
    check(e_mark == 0, "R2 mark cycle mismatches", e_mark, 0);
    check(e_data == 0, "R3 data bit mismatches", e_data, 0);
    check(e_par == 0, "R4 parity bit mismatches", e_par, 0);
    check(e_tail == 0, "R5 tail drive mismatches", e_tail, 0);
    check(e_rdy == 0, "R6 tx_ready mismatches", e_rdy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(line_oe == 1'b0, "R10 line_oe in reset", int'(line_oe), 0);
    check(tx_ready == 1'b1, "R10 tx_ready in reset", int'(tx_ready), 1);
    check(rx_valid == 1'b0, "R10 rx_valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_oe == 1'b0 && line_in == 1'b1, "R10 line released after reset", int'(line_oe), 0);

    // Receiver fed by the peer: clean chunks and injected parity faults (R7, R8).
    peer_chunk(8'hA5, 1'b0, 1'b1);
    peer_chunk(8'h3C, 1'b1, 1'b1);
    peer_chunk(8'h80, 1'b0, 1'b1);
    peer_chunk(8'h00, 1'b0, 1'b1);
    peer_chunk(8'hFE, 1'b1, 1'b1);

    // R9: hold the result; the next chunk passes uncaptured.
    hold_rx = 1'b1;
    peer_chunk(8'h5A, 1'b0, 1'b1);
    peer_chunk(8'hC3, 1'b0, 1'b0);
    @(negedge clk);
    check(rx_valid == 1'b1, "R9 result still waiting", int'(rx_valid), 1);
    check(rx_data == 8'h5A, "R9 held data unchanged", int'(rx_data), 8'h5A);
    hold_rx = 1'b0;
    peer_chunk(8'h69, 1'b0, 1'b1);

    // Peer lets go: the rise reads as a chunk of ones with a bad parity bit (R7, R8).
    exp_q.push_back({1'b1, 8'hFF});
    @(negedge clk);
    peer_low = 1'b0;
    repeat (14 * T) @(negedge clk);
    check(exp_q.size() == 0, "R7 all peer chunks received", exp_q.size(), 0);

    // Transmitter frames, looped back through the receiver.
    tx_chunk(8'hB4, 1'b0);
    tx_chunk(8'h01, 1'b1);
    tx_chunk(8'hFE, 1'b0);
    repeat (20) @(negedge clk);
    check(line_oe && !line_out, "R5 line held low while idle", int'(line_out), 0);
    repeat (4 * T) @(negedge clk);
    check(exp_q.size() == 0, "R7 loop-back chunks received", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule